// File: doc/BRIEF.md
# I2C Command-Byte Register Target

This block is the bus-facing half of a 16-bit port expander. It watches a two-wire serial bus with a fast system clock and reacts to a 7-bit target address. The upper four address bits are fixed by a parameter and the lower three come from strap pins, so up to eight of these targets can share one bus. After the address byte, the first byte of a write transfer is a command byte. The command byte points at one of twelve 8-bit registers, which are arranged in pairs, one register of each pair for each 8-bit port.

The register file itself is outside this block. The block reaches it through a select bus, a one-cycle write strobe, a one-cycle read strobe and a read-data input that follows the select combinationally. The block filters register accesses itself. Writes to the two interrupt-capture registers, and writes to command values past the last register, never reach the strobe. Reads of command values past the last register return zero, whatever the register file presents.

A read works in one of two ways. The usual sequence writes a command byte, then sends a repeated START and a read address. A read address sent on its own reads whichever register the pointer currently holds.

Top module: `i2c_cmd_target`

## Requirements
- R1: The target answers only address {0100b, dev_pins[2:0]}, with address bit 6 sent first and the R/W bit (1 = read) last. It acknowledges by pulling SDA low (sda_oe = 1) through the ninth clock. For any other address it gives no acknowledge and leaves SDA released until the next START.
- R2: In a write transfer, the first byte after the address is the command byte. Each later byte is acknowledged and produces exactly one single-cycle reg_wr pulse, with reg_sel equal to the command's low four bits and reg_wdata equal to the byte. The pointer stays on the same register for every data byte.
- R3: Commands 8h and 9h select the interrupt-capture pair, which is read-only. Data bytes written to them are acknowledged but produce no reg_wr pulse.
- R4: A command byte above Bh is still acknowledged. Data written after it produces no reg_wr pulse, and reads of it return 00h.
- R5: After a read address, the target drives the selected register MSB first, each bit stable while SCL is high. A master ACK causes the same register to be sent again. After a master NACK, the target releases SDA.
- R6: A repeated START keeps the command pointer. A STOP or a reset sets the pointer to register 0, so a read with no command byte returns register 0.
- R7: Every register from 0h to Bh can be read back through the bus.
- R8: An SDA fall while SCL is high is a START at any point, even in the middle of a byte, and restarts the address phase. Transfers work the same at any SCL rate whose half period covers at least a few system clocks.
- R9: During and after reset, sda_oe, reg_wr and reg_rd are low and reg_sel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_pins | input | 3 | Strap pins giving the low three address bits |
| scl_i | input | 1 | Bus clock as seen on the pad |
| sda_i | input | 1 | Bus data as seen on the pad (wired-AND line) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_sel | output | SEL_W | Register select (command pointer low bits) |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle strobe when a register byte is loaded for sending |
| reg_wdata | output | 8 | Write data, valid with reg_wr |
| reg_rdata | input | 8 | Register contents for reg_sel, combinational |

## Verification
The bench builds the block with its default parameters: address prefix 0100b, twelve registers, read-only pair at 8h/9h, a 4-bit select and two synchronizer stages. The strap pins start at 101b and are later changed to 010b. The bench's own register file returns EEh for selects 12 to 15, so any read of an out-of-range command that is not replaced by zero shows up at once. The bench runs SCL half periods of 12, 30, 125 and 300 system clocks. The shortest of these brings the synchronizer latency close to the bit time. The longest matches a bus much slower than 400 kbit/s.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_OUT,
    ST_TX,
    ST_ACK_IN
  } tgt_state_t;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_CMD,
    BK_DATA
  } byte_kind_t;

  // Device address match on the seven bits shifted in before R/W.
  function automatic logic addr_hit(input logic [ADDR_W-1:0] rx,
                                    input logic [ADDR_W-1:0] mine);
    return rx == mine;
  endfunction

  // A command value names a real register.
  function automatic logic cmd_readable(input logic [BYTE_W-1:0] cmd,
                                        input int nregs);
    return int'(cmd) < nregs;
  endfunction

  // A command value names a real register outside the read-only window.
  function automatic logic cmd_writable(input logic [BYTE_W-1:0] cmd,
                                        input int nregs, input int ro_lo,
                                        input int ro_hi);
    return cmd_readable(cmd, nregs) &&
           !(int'(cmd) >= ro_lo && int'(cmd) <= ro_hi);
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d, scl_s;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_p[g] <= 1'b1;
          sda_p[g] <= 1'b1;
        end else begin
          scl_p[g] <= scl_i;
          sda_p[g] <= sda_i;
        end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_p[g] <= 1'b1;
          sda_p[g] <= 1'b1;
        end else begin
          scl_p[g] <= scl_p[g-1];
          sda_p[g] <= sda_p[g-1];
        end
    end
  end

  assign scl_s = scl_p[STAGES-1];
  assign sda_s = sda_p[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_cmd_gate.sv
module i2c_cmd_gate
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_REGS = 12,
  parameter int RO_LO    = 8,
  parameter int RO_HI    = 9,
  parameter int SEL_W    = 4
) (
  input  logic [BYTE_W-1:0] cmd_q,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic [SEL_W-1:0]  reg_sel,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [BYTE_W-1:0] rd_byte
);
  logic rd_ok, wr_ok;

  assign rd_ok   = cmd_readable(cmd_q, NUM_REGS);
  assign wr_ok   = cmd_writable(cmd_q, NUM_REGS, RO_LO, RO_HI);
  assign reg_sel = cmd_q[SEL_W-1:0];
  assign reg_wr  = wr_req & wr_ok;
  assign reg_rd  = rd_req & rd_ok;
  assign rd_byte = rd_ok ? reg_rdata : '0;
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [BYTE_W-1:0] cmd_q,
  output logic [BYTE_W-1:0] wdata,
  output logic              wr_req,
  output logic              rd_req,
  output logic              sda_oe
);
  tgt_state_t        state;
  byte_kind_t        kind;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              rw, m_ack;

  assign wdata = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kind   <= BK_ADDR;
      cnt    <= '0;
      rx_sh  <= '0;
      tx_sh  <= '0;
      rw     <= 1'b0;
      m_ack  <= 1'b0;
      cmd_q  <= '0;
      sda_oe <= 1'b0;
      wr_req <= 1'b0;
      rd_req <= 1'b0;
    end else begin
      wr_req <= 1'b0;
      rd_req <= 1'b0;
      if (stop_evt) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        cmd_q  <= '0;
      end else if (start_evt) begin
        state  <= ST_RX;
        kind   <= BK_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise) begin
              rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
              cnt <= '0;
              unique case (kind)
                BK_ADDR: begin
                  if (addr_hit(rx_sh[BYTE_W-1:1], dev_addr)) begin
                    rw     <= rx_sh[0];
                    state  <= ST_ACK_OUT;
                    sda_oe <= 1'b1;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                BK_CMD: begin
                  cmd_q  <= rx_sh;
                  state  <= ST_ACK_OUT;
                  sda_oe <= 1'b1;
                end
                default: begin
                  wr_req <= 1'b1;
                  state  <= ST_ACK_OUT;
                  sda_oe <= 1'b1;
                end
              endcase
            end
          end
          ST_ACK_OUT: begin
            if (scl_fall) begin
              if (kind == BK_ADDR && rw) begin
                state  <= ST_TX;
                tx_sh  <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
                rd_req <= 1'b1;
                cnt    <= '0;
              end else begin
                state  <= ST_RX;
                sda_oe <= 1'b0;
                kind   <= (kind == BK_ADDR) ? BK_CMD : BK_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == CNT_W'(BYTE_W - 1)) begin
                state  <= ST_ACK_IN;
                sda_oe <= 1'b0;
              end else begin
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx_sh[BYTE_W-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_ACK_IN: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (m_ack) begin
                state  <= ST_TX;
                tx_sh  <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
                rd_req <= 1'b1;
                cnt    <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [3:0] ADDR_HI     = 4'b0100,
  parameter int         NUM_REGS    = 12,
  parameter int         RO_LO       = 8,
  parameter int         RO_HI       = 9,
  parameter int         SEL_W       = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-$bits(ADDR_HI)-1:0] dev_pins,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe,
  output logic [SEL_W-1:0]         reg_sel,
  output logic                     reg_wr,
  output logic                     reg_rd,
  output logic [BYTE_W-1:0]        reg_wdata,
  input  logic [BYTE_W-1:0]        reg_rdata
);
  // Named internal events, exposed to the bound checker.
  logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic              wr_req, rd_req;
  logic [BYTE_W-1:0] cmd_q, rd_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_tgt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .dev_addr({ADDR_HI, dev_pins}),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .rd_byte(rd_byte),
    .cmd_q(cmd_q), .wdata(reg_wdata), .wr_req(wr_req), .rd_req(rd_req),
    .sda_oe(sda_oe)
  );

  i2c_cmd_gate #(
    .NUM_REGS(NUM_REGS), .RO_LO(RO_LO), .RO_HI(RO_HI), .SEL_W(SEL_W)
  ) u_gate (
    .cmd_q(cmd_q), .wr_req(wr_req), .rd_req(rd_req), .reg_rdata(reg_rdata),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd), .rd_byte(rd_byte)
  );
endmodule

// File: rtl/i2c_cmd_target_chk.sv
module i2c_cmd_target_chk #(
  parameter int NUM_REGS = 12,
  parameter int RO_LO    = 8,
  parameter int RO_HI    = 9,
  parameter int SEL_W    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [SEL_W-1:0] reg_sel,
  input logic             scl_fall,
  input logic             stop_evt
);
  // R2: a data byte gives one strobe, never two in a row
  assert_wr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R3: strobed writes land only on real, writable registers
  assert_wr_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (int'(reg_sel) < NUM_REGS) &&
               !(int'(reg_sel) >= RO_LO && int'(reg_sel) <= RO_HI));

  // R4: read strobes only for real registers
  assert_rd_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> int'(reg_sel) < NUM_REGS);

  // R1: SDA is only ever pulled after an SCL fall
  assert_oe_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R6: STOP releases the line and resets the pointer
  assert_stop_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe && reg_sel == '0);
endmodule

bind i2c_cmd_target i2c_cmd_target_chk #(
  .NUM_REGS(NUM_REGS), .RO_LO(RO_LO), .RO_HI(RO_HI), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_sel(reg_sel), .scl_fall(scl_fall),
  .stop_evt(stop_evt)
);

// File: tb/tb_i2c_cmd_target.sv
`timescale 1ns/1ps
module tb_i2c_cmd_target;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] dev_pins = 3'b101;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe, reg_wr, reg_rd;
  logic [3:0] reg_sel;
  logic [7:0] reg_wdata, reg_rdata;
  wire        sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_cmd_target dut (
    .clk(clk), .rst_n(rst_n), .dev_pins(dev_pins), .scl_i(scl_m),
    .sda_i(sda_line), .sda_oe(sda_oe), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int checks = 0, errors = 0, half = 30;
  bit done = 0, quiet = 0;
  int quiet_bad = 0;

  // Bench register file: 12 bytes, out-of-range selects read EEh.
  logic [7:0] mem [0:11];
  logic [7:0] model [0:11];
  function automatic logic [7:0] seed(int i);
    return 8'(i * 37 + 11);
  endfunction
  assign reg_rdata = (reg_sel < 4'd12) ? mem[reg_sel] : 8'hEE;
  always @(posedge clk)
    if (!rst_n) for (int i = 0; i < 12; i++) mem[i] <= seed(i);
    else if (reg_wr && reg_sel < 4'd12) mem[reg_sel] <= reg_wdata;

  // Expected write strobes, compared every clock.
  logic [3:0] q_sel[$];
  logic [7:0] q_dat[$];
  always @(negedge clk) if (rst_n && !done) begin
    if (quiet && sda_oe) quiet_bad++;
    if (reg_wr) begin
      checks++;
      if (q_sel.size() == 0) begin
        errors++;
        $display("FAIL R2/R3/R4 unexpected write sel=%0h data=%02h expected none",
                 reg_sel, reg_wdata);
      end else begin
        if (reg_sel !== q_sel[0] || reg_wdata !== q_dat[0]) begin
          errors++;
          $display("FAIL R2 write sel=%0h data=%02h expected sel=%0h data=%02h",
                   reg_sel, reg_wdata, q_sel[0], q_dat[0]);
        end
        void'(q_sel.pop_front());
        void'(q_dat.pop_front());
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic start_c();
    sda_m = 1'b1; w(half); scl_m = 1'b1; w(half);
    sda_m = 1'b0; w(half); scl_m = 1'b0; w(half);
  endtask
  task automatic stop_c();
    sda_m = 1'b0; w(half); scl_m = 1'b1; w(half); sda_m = 1'b1; w(half);
  endtask
  task automatic put_bit(input bit b);
    sda_m = b; w(half); scl_m = 1'b1; w(half); scl_m = 1'b0;
  endtask
  task automatic get_bit(output bit b);
    sda_m = 1'b1; w(half); scl_m = 1'b1; w(half / 2);
    b = sda_line; w(half - half / 2); scl_m = 1'b0;
  endtask
  task automatic send(input logic [7:0] b, input bit exp_ack, input string tag);
    bit a;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    check(!a == exp_ack, tag, !a, exp_ack);
  endtask
  task automatic recv(input logic [7:0] exp, input bit give_ack, input string tag);
    logic [7:0] b;
    bit x;
    for (int i = 7; i >= 0; i--) begin get_bit(x); b[i] = x; end
    put_bit(!give_ack);
    check(b == exp, tag, b, exp);
  endtask

  function automatic logic [7:0] addr_byte(input bit rd);
    return {4'b0100, dev_pins, rd};
  endfunction
  function automatic logic [7:0] exp_read(input int cmd);
    return (cmd < 12) ? model[cmd] : 8'h00;
  endfunction
  function automatic bit writable(input int cmd);
    return cmd < 12 && cmd != 8 && cmd != 9;
  endfunction

  task automatic wr_reg(input int cmd, input logic [7:0] d, input string tag);
    start_c();
    send(addr_byte(0), 1, {tag, " addr ack"});
    send(8'(cmd), 1, {tag, " cmd ack"});
    if (writable(cmd)) begin
      q_sel.push_back(4'(cmd)); q_dat.push_back(d); model[cmd] = d;
    end
    send(d, 1, {tag, " data ack"});
    stop_c();
  endtask

  task automatic rd_reg(input int cmd, input int n, input string tag);
    start_c();
    send(addr_byte(0), 1, {tag, " addr ack"});
    send(8'(cmd), 1, {tag, " cmd ack"});
    start_c();
    send(addr_byte(1), 1, {tag, " raddr ack"});
    for (int i = 0; i < n; i++) recv(exp_read(cmd), i < n - 1, {tag, " data"});
    w(6);
    check(sda_oe == 1'b0, "R5 released after NACK", sda_oe, 0);
    stop_c();
  endtask

  initial begin
    for (int i = 0; i < 12; i++) model[i] = seed(i);
    w(5); rst_n = 1'b1; w(5);
    // R9: reset state
    check(sda_oe == 0 && reg_wr == 0 && reg_rd == 0, "R9 outputs idle", {sda_oe, reg_wr, reg_rd}, 0);
    check(reg_sel == 0, "R9 pointer", reg_sel, 0);

    // R1: foreign address is ignored
    quiet = 1;
    start_c();
    send(8'h48, 0, "R1 foreign addr nack");
    send(8'h02, 0, "R1 foreign byte nack");
    stop_c();
    quiet = 0;
    check(quiet_bad == 0, "R1 SDA never pulled on mismatch", quiet_bad, 0);

    // R2, R5: write then read back, multi-byte read
    wr_reg(2, 8'hA5, "R2");
    rd_reg(2, 3, "R5 repeat same reg");
    wr_reg(6, 8'h3C, "R2 dir");
    rd_reg(6, 1, "R2 readback");

    // R2: several data bytes stay on the same register
    start_c();
    send(addr_byte(0), 1, "R2 addr"); send(8'h04, 1, "R2 cmd");
    q_sel.push_back(4); q_dat.push_back(8'h11); send(8'h11, 1, "R2 d1");
    q_sel.push_back(4); q_dat.push_back(8'h96); send(8'h96, 1, "R2 d2");
    model[4] = 8'h96;
    stop_c();
    rd_reg(4, 1, "R2 last byte kept");

    // R3: read-only capture pair
    wr_reg(8, 8'h00, "R3 cap0");
    wr_reg(9, 8'hFF, "R3 cap1");
    rd_reg(8, 1, "R3 cap0 unchanged");
    rd_reg(9, 1, "R3 cap1 unchanged");

    // R4: out-of-range command
    wr_reg(12, 8'h55, "R4 write");
    rd_reg(13, 2, "R4 reads zero");
    rd_reg(15, 1, "R4 reads zero top");

    // R6: STOP resets pointer; read without command returns register 0
    wr_reg(0, 8'hC3, "R6 set reg0");
    wr_reg(3, 8'h7E, "R6 set reg3");
    start_c();
    send(addr_byte(1), 1, "R6 raddr");
    recv(model[0], 0, "R6 pointer reset to 0");
    stop_c();

    // R7: every register readable
    for (int c = 0; c < 12; c++) rd_reg(c, 1, "R7 readable");

    // R8: START mid-byte restarts address phase
    start_c();
    send(addr_byte(0), 1, "R8 addr"); send(8'h01, 1, "R8 cmd");
    put_bit(1); put_bit(0); put_bit(1); put_bit(1);
    start_c();
    send(addr_byte(0), 1, "R8 addr after restart");
    send(8'h05, 1, "R8 cmd after restart");
    q_sel.push_back(5); q_dat.push_back(8'h77); model[5] = 8'h77;
    send(8'h77, 1, "R8 data");
    stop_c();
    rd_reg(5, 1, "R8 restart write landed");
    rd_reg(1, 1, "R8 aborted byte dropped");

    // R8: SCL rate independence
    half = 12;  wr_reg(7, 8'h0F, "R8 fast"); rd_reg(7, 2, "R8 fast");
    half = 125; wr_reg(10, 8'h81, "R8 400k"); rd_reg(10, 1, "R8 400k");
    half = 300; wr_reg(11, 8'h24, "R8 slow"); rd_reg(11, 1, "R8 slow");
    half = 30;

    // R1: address pins change the address
    dev_pins = 3'b010;
    quiet = 1; quiet_bad = 0;
    start_c(); send(8'h4A, 0, "R1 old address now foreign"); stop_c();
    quiet = 0;
    check(quiet_bad == 0, "R1 quiet on old address", quiet_bad, 0);
    rd_reg(3, 1, "R1 new address");

    w(20);
    check(q_sel.size() == 0, "R2 all expected writes seen", q_sel.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule